// File: doc/BRIEF.md
# Doorbell Mailbox with Shared Buffer

This block connects a host processor and a remote processor through a 256-byte shared message buffer and two 32-bit doorbell registers. To send, the host writes its message into the buffer and then sets one bit in the send doorbell. The remote side reads the message and acknowledges by clearing that bit. The host learns that the send is complete only by reading the bit back as zero. No completion interrupt exists.

In the other direction, the remote side raises bits in the receive flag register. While any of these bits is set, a level interrupt to the host stays asserted. The host reads the flags and the buffer, then clears the flags it has handled by writing ones to them. Each side has its own simple word-wide register port with a fixed one-cycle read latency.

Top module: `doorbell_mailbox`

## Requirements
- R1: A word written to buffer offset 0x000 to 0x0FF on the host port can be read back at the same offset on both ports. The buffer holds 64 words of 32 bits.
- R2: A word that the remote port writes to the buffer can be read back at the same offset on the host port.
- R3: A host write to offset 0x100 sets every send doorbell bit that is one in the data and leaves the other bits unchanged. A read of 0x100 on either port returns the pending send bits.
- R4: A remote write to offset 0x100 clears every send doorbell bit that is one in the data. Zero bits in the data leave the register unchanged.
- R5: A remote write to offset 0x10C sets every receive flag bit that is one in the data. A read of 0x10C on either port returns the receive flags.
- R6: A host write to offset 0x10C clears every receive flag bit that is one in the data. Zero bits in the data have no effect.
- R7: host_irq is high exactly while at least one receive flag bit is set. It changes in the same cycle as the flag register.
- R8: When a set and a clear reach the same doorbell or flag bit in one cycle, the bit ends up set.
- R9: Read data appears on the cycle after the read strobe. In any cycle that follows a cycle without a read strobe, the read data is zero.
- R10: A read from an unmapped offset (0x104, 0x108, and 0x110 to 0x1FC) returns zero. A write to an unmapped offset changes no register and no buffer word.
- R11: A synchronous active-low reset clears both doorbell registers and both read data outputs and deasserts host_irq. Reset leaves the buffer contents undefined.
- R12: If both ports write the same buffer word in one cycle, the host data is stored. A read of a word in the same cycle as a write to it returns the old contents.
- R13: Address bits 1:0 are ignored, so any byte address inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 9 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid one cycle after host_rd |
| host_irq | output | 1 | Level interrupt, high while any receive flag is set |
| rem_addr | input | 9 | Remote byte offset |
| rem_wr | input | 1 | Remote write strobe |
| rem_rd | input | 1 | Remote read strobe |
| rem_wdata | input | 32 | Remote write data |
| rem_rdata | output | 32 | Remote read data, valid one cycle after rem_rd |

## Verification
The assertions assume that a strobe is held for exactly one clock and that the address and write data are stable while it is high. They also assume that only a nonzero remote write to 0x10C can raise a receive flag, which requires that the ports carry no unknown values after reset. The bench drives every strobe for a single cycle from the falling edge and keeps all inputs at zero between operations. Each burst of simultaneous traffic is a single deliberate cycle in which both ports act together.

// File: rtl/mbox_pkg.sv
// Package: shared types for the doorbell mailbox.
// Assumes: one address region is selected per access on each port.
package mbox_pkg;

    // Region selected by a port address
    typedef enum logic [1:0] {
        RGN_BUF  = 2'd0,
        RGN_TX   = 2'd1,
        RGN_RX   = 2'd2,
        RGN_NONE = 2'd3
    } mbox_region_e;

endpackage

// File: rtl/mbox_bell_reg.sv
// Module: a bit-set / bit-clear register for doorbell signals.
// Assumes: set and clear masks are only looked at while their enables are high.
// A set and a clear of the same bit in one cycle leave the bit set.
module mbox_bell_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [WIDTH-1:0] set_mask,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] set_bits;
    logic [WIDTH-1:0] clr_bits;

    // Mask gating: an idle strobe contributes no bits
    always_comb begin
        set_bits = set_en ? set_mask : '0;
        clr_bits = clr_en ? clr_mask : '0;
    end

    // State update: clear first, then set, so that a set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_bits) | set_bits;
        end
    end

endmodule

// File: rtl/mbox_buffer.sv
// Module: shared word buffer with two write ports and two asynchronous read ports.
// Assumes: callers register the read data. A collision of the two writes on one
// word stores the A-port data. The contents are not reset.
module mbox_buffer #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Per-word write: A port has priority over B port
        always_ff @(posedge clk) begin
            if (a_we && (a_idx == IDX_W'(w))) begin
                mem[w] <= a_wdata;
            end else if (b_we && (b_idx == IDX_W'(w))) begin
                mem[w] <= b_wdata;
            end
        end
    end

    // Read selection: returns the contents before this cycle's writes
    always_comb begin
        a_rdata = mem[a_idx];
        b_rdata = mem[b_idx];
    end

endmodule

// File: rtl/mbox_port.sv
// Module: one register-bus port. It decodes the address into a buffer word,
// the send doorbell, the receive flags or an unmapped hole. It produces the
// write strobes and returns registered read data one cycle after a read.
// Assumes: address bits below the word size are ignored.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int              ADDR_W    = 9,
    parameter int              DATA_W    = 32,
    parameter int              BUF_WORDS = 64,
    parameter int              IDX_W     = 6,
    parameter int              LSB       = 2,
    parameter logic [ADDR_W-1:0] TX_OFS  = 9'h100,
    parameter logic [ADDR_W-1:0] RX_OFS  = 9'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] buf_word,
    input  logic [DATA_W-1:0] tx_q,
    input  logic [DATA_W-1:0] rx_q,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              buf_we,
    output logic              tx_wr,
    output logic              rx_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WA_W = ADDR_W - LSB;
    localparam logic [WA_W-1:0] BUF_END = WA_W'(BUF_WORDS);
    localparam logic [WA_W-1:0] TX_WA   = TX_OFS[ADDR_W-1:LSB];
    localparam logic [WA_W-1:0] RX_WA   = RX_OFS[ADDR_W-1:LSB];

    logic [WA_W-1:0] word_addr;
    logic            unused_byte_lane;
    mbox_region_e    region;
    logic [DATA_W-1:0] rd_val;

    assign word_addr        = addr[ADDR_W-1:LSB];
    assign unused_byte_lane = ^addr[LSB-1:0];
    assign buf_idx          = word_addr[IDX_W-1:0];

    // Address decode into one region
    always_comb begin
        if (word_addr < BUF_END) begin
            region = RGN_BUF;
        end else if (word_addr == TX_WA) begin
            region = RGN_TX;
        end else if (word_addr == RX_WA) begin
            region = RGN_RX;
        end else begin
            region = RGN_NONE;
        end
    end

    // Write strobes: only a mapped region receives a write
    always_comb begin
        buf_we = wr && (region == RGN_BUF);
        tx_wr  = wr && (region == RGN_TX);
        rx_wr  = wr && (region == RGN_RX);
    end

    // Read mux: unmapped offsets read as zero
    always_comb begin
        unique case (region)
            RGN_BUF: rd_val = buf_word;
            RGN_TX:  rd_val = tx_q;
            RGN_RX:  rd_val = rx_q;
            default: rd_val = '0;
        endcase
    end

    // Read data register: one-cycle latency, zero after an idle cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? rd_val : '0;
        end
    end

endmodule

// File: rtl/doorbell_mailbox.sv
// Module: two-port doorbell mailbox (top). The host sets send bits and the
// remote clears them. The remote sets receive flags and the host clears them
// (write-one-to-clear). Both ports share a word buffer. host_irq is high
// while any receive flag is set.
// Assumes: one clock domain for both ports and a synchronous active-low reset.
module doorbell_mailbox #(
    parameter int              ADDR_W    = 9,
    parameter int              DATA_W    = 32,
    parameter int              BUF_BYTES = 256,
    parameter logic [ADDR_W-1:0] TX_OFS  = 9'h100,
    parameter logic [ADDR_W-1:0] RX_OFS  = 9'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic [ADDR_W-1:0] rem_addr,
    input  logic              rem_wr,
    input  logic              rem_rd,
    input  logic [DATA_W-1:0] rem_wdata,
    output logic [DATA_W-1:0] rem_rdata
);

    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int LSB            = $clog2(BYTES_PER_WORD);
    localparam int BUF_WORDS      = BUF_BYTES / BYTES_PER_WORD;
    localparam int IDX_W          = $clog2(BUF_WORDS);

    logic [DATA_W-1:0] tx_q, rx_q;
    logic [DATA_W-1:0] h_buf_word, r_buf_word;
    logic [IDX_W-1:0]  h_idx, r_idx;
    logic              h_buf_we, r_buf_we;
    logic              h_tx_wr, h_rx_wr, r_tx_wr, r_rx_wr;

    mbox_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS),
        .IDX_W(IDX_W), .LSB(LSB), .TX_OFS(TX_OFS), .RX_OFS(RX_OFS)
    ) u_host_port (
        .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr), .rd(host_rd),
        .buf_word(h_buf_word), .tx_q(tx_q), .rx_q(rx_q),
        .buf_idx(h_idx), .buf_we(h_buf_we), .tx_wr(h_tx_wr), .rx_wr(h_rx_wr),
        .rdata(host_rdata)
    );

    mbox_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS),
        .IDX_W(IDX_W), .LSB(LSB), .TX_OFS(TX_OFS), .RX_OFS(RX_OFS)
    ) u_rem_port (
        .clk(clk), .rst_n(rst_n), .addr(rem_addr), .wr(rem_wr), .rd(rem_rd),
        .buf_word(r_buf_word), .tx_q(tx_q), .rx_q(rx_q),
        .buf_idx(r_idx), .buf_we(r_buf_we), .tx_wr(r_tx_wr), .rx_wr(r_rx_wr),
        .rdata(rem_rdata)
    );

    mbox_buffer #(
        .WORDS(BUF_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_buffer (
        .clk(clk),
        .a_we(h_buf_we), .a_idx(h_idx), .a_wdata(host_wdata), .a_rdata(h_buf_word),
        .b_we(r_buf_we), .b_idx(r_idx), .b_wdata(rem_wdata), .b_rdata(r_buf_word)
    );

    // Send doorbell: host sets, remote acknowledges by clearing
    mbox_bell_reg #(.WIDTH(DATA_W)) u_tx_bell (
        .clk(clk), .rst_n(rst_n),
        .set_en(h_tx_wr), .set_mask(host_wdata),
        .clr_en(r_tx_wr), .clr_mask(rem_wdata),
        .q(tx_q)
    );

    // Receive flags: remote sets, host clears with write-one-to-clear
    mbox_bell_reg #(.WIDTH(DATA_W)) u_rx_flags (
        .clk(clk), .rst_n(rst_n),
        .set_en(r_rx_wr), .set_mask(rem_wdata),
        .clr_en(h_rx_wr), .clr_mask(host_wdata),
        .q(rx_q)
    );

    // Level interrupt: any pending receive flag
    assign host_irq = |rx_q;

endmodule

// File: rtl/mbox_checker.sv
// Module: assertion checker for doorbell_mailbox, attached by bind.
// Assumes: strobes last one cycle, and the address is stable while a strobe is high.
module mbox_checker #(
    parameter int              ADDR_W    = 9,
    parameter int              DATA_W    = 32,
    parameter int              BUF_BYTES = 256,
    parameter logic [ADDR_W-1:0] TX_OFS  = 9'h100,
    parameter logic [ADDR_W-1:0] RX_OFS  = 9'h10C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_irq,
    input logic [ADDR_W-1:0] rem_addr,
    input logic              rem_wr,
    input logic              rem_rd,
    input logic [DATA_W-1:0] rem_wdata,
    input logic [DATA_W-1:0] rem_rdata
);

    localparam int LSB  = $clog2(DATA_W / 8);
    localparam int WA_W = ADDR_W - LSB;
    localparam logic [WA_W-1:0] BUF_END = WA_W'(BUF_BYTES / (DATA_W / 8));
    localparam logic [WA_W-1:0] TX_WA   = TX_OFS[ADDR_W-1:LSB];
    localparam logic [WA_W-1:0] RX_WA   = RX_OFS[ADDR_W-1:LSB];

    logic [WA_W-1:0] hwa, rwa;
    logic rx_set_req, rx_clr_req, h_unmapped, unused_lanes;

    assign hwa          = host_addr[ADDR_W-1:LSB];
    assign rwa          = rem_addr[ADDR_W-1:LSB];
    assign unused_lanes = ^{host_addr[LSB-1:0], rem_addr[LSB-1:0]};
    assign rx_set_req   = rem_wr && (rwa == RX_WA) && (rem_wdata != '0);
    assign rx_clr_req   = host_wr && (hwa == RX_WA);
    assign h_unmapped   = (hwa >= BUF_END) && (hwa != TX_WA) && (hwa != RX_WA);

    assert_rx_set_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set_req |=> host_irq);

    assert_irq_clear_only_by_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !rx_clr_req) |=> host_irq);

    assert_irq_no_spurious_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq && !rx_set_req) |=> !host_irq);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_req && rx_clr_req) |=> host_irq);

    assert_idle_host_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> (host_rdata == '0));

    assert_idle_rem_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rem_rd |=> (rem_rdata == '0));

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && h_unmapped) |=> (host_rdata == '0));

    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (!host_irq && host_rdata == '0 && rem_rdata == '0));

endmodule

bind doorbell_mailbox mbox_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES),
    .TX_OFS(TX_OFS), .RX_OFS(RX_OFS)
) u_mbox_checker (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .rem_addr(rem_addr), .rem_wr(rem_wr), .rem_rd(rem_rd),
    .rem_wdata(rem_wdata), .rem_rdata(rem_rdata)
);

// File: tb/tb_doorbell_mailbox.sv
// Bench: sweeps every buffer word, every doorbell bit and every unmapped
// offset of the default configuration. Expected values come from a small
// arithmetic model held in the bench.
module tb_doorbell_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam logic [8:0] TX = 9'h100;
    localparam logic [8:0] RX = 9'h10C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  host_addr = '0, rem_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0, rem_wr = 1'b0, rem_rd = 1'b0;
    logic [31:0] host_wdata = '0, rem_wdata = '0;
    logic [31:0] host_rdata, rem_rdata;
    logic        host_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] exp_tx, exp_rx;

    doorbell_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .rem_addr(rem_addr), .rem_wr(rem_wr), .rem_rd(rem_rd),
        .rem_wdata(rem_wdata), .rem_rdata(rem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input int i);
        return (32'h9E3779B9 * (i + 1)) ^ 32'h0F0F1234;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One bus cycle on both ports, entered and left at a falling edge
    task automatic cyc(input logic hw, input logic hr, input logic [8:0] ha, input logic [31:0] hd,
                       input logic rw, input logic rr, input logic [8:0] ra, input logic [31:0] rd);
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        rem_wr = rw;  rem_rd = rr;  rem_addr = ra;  rem_wdata = rd;
        @(negedge clk);
        host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
        rem_wr = 0;  rem_rd = 0;  rem_addr = '0;  rem_wdata = '0;
    endtask

    task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, '0, '0);
    endtask
    task automatic rwrite(input logic [8:0] a, input logic [31:0] d);
        cyc(0, 0, '0, '0, 1, 0, a, d);
    endtask
    task automatic hread(input logic [8:0] a, output logic [31:0] d);
        cyc(0, 1, a, '0, 0, 0, '0, '0);
        d = host_rdata;
    endtask
    task automatic rread(input logic [8:0] a, output logic [31:0] d);
        cyc(0, 0, '0, '0, 0, 1, a, '0);
        d = rem_rdata;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R11 irq in reset", {31'd0, host_irq}, 32'd0);
        chk("R11 host rdata in reset", host_rdata, 32'd0);
        chk("R11 rem rdata in reset", rem_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        hread(TX, v); chk("R11 tx after reset", v, 32'd0);
        hread(RX, v); chk("R11 rx after reset", v, 32'd0);
        exp_tx = '0; exp_rx = '0;

        // R1: host fills every word; both ports read back, with R13 byte lanes
        for (int i = 0; i < 64; i++) hwrite(9'(i*4 + (i % 4)), pat(i));
        for (int i = 0; i < 64; i++) begin
            rread(9'(i*4), v);           chk("R1 remote reads host word", v, pat(i));
            hread(9'(i*4 + 3 - (i % 4)), v); chk("R13 host reads any lane", v, pat(i));
        end
        cyc(0, 0, '0, '0, 0, 0, '0, '0);
        chk("R9 host idle rdata", host_rdata, 32'd0);
        chk("R9 rem idle rdata", rem_rdata, 32'd0);

        // R2: remote fills every word; host reads back
        for (int i = 0; i < 64; i++) rwrite(9'(i*4), ~pat(i));
        for (int i = 0; i < 64; i++) begin
            hread(9'(i*4), v); chk("R2 host reads remote word", v, ~pat(i));
        end

        // R3 and R4: send doorbell set by host, cleared by remote
        for (int k = 0; k < 32; k++) begin
            hwrite(TX, 32'd1 << k); exp_tx |= 32'd1 << k;
            hread(TX, v); chk("R3 host sees pending", v, exp_tx);
            rread(TX, v); chk("R3 remote sees pending", v, exp_tx);
        end
        rwrite(TX, 32'd0);
        hread(TX, v); chk("R4 zero clear no effect", v, exp_tx);
        for (int k = 31; k >= 0; k--) begin
            rwrite(TX, 32'd1 << k); exp_tx &= ~(32'd1 << k);
            hread(TX, v); chk("R4 remote clear", v, exp_tx);
        end

        // R5, R6, R7: receive flags and interrupt
        for (int k = 0; k < 32; k++) begin
            rwrite(RX, 32'd1 << k); exp_rx |= 32'd1 << k;
            chk("R7 irq raised", {31'd0, host_irq}, 32'd1);
            hread(RX, v); chk("R5 host sees flags", v, exp_rx);
        end
        rread(RX, v); chk("R5 remote sees flags", v, exp_rx);
        hwrite(RX, 32'd0);
        hread(RX, v); chk("R6 zero clear no effect", v, exp_rx);
        for (int k = 0; k < 32; k++) begin
            hwrite(RX, 32'd1 << k); exp_rx &= ~(32'd1 << k);
            chk("R7 irq level", {31'd0, host_irq}, {31'd0, exp_rx != 0});
            hread(RX, v); chk("R6 host clear", v, exp_rx);
        end

        // R8: set and clear of the same bit in one cycle
        hwrite(TX, 32'h8); exp_tx = 32'h8;
        cyc(1, 0, TX, 32'h8, 1, 0, TX, 32'hFFFF_FFFF);
        hread(TX, v); chk("R8 tx set wins", v, exp_tx);
        rwrite(RX, 32'h10); exp_rx = 32'h10;
        cyc(1, 0, RX, 32'hFFFF_FFFF, 1, 0, RX, 32'h10);
        chk("R8 irq kept", {31'd0, host_irq}, 32'd1);
        hread(RX, v); chk("R8 rx set wins", v, exp_rx);

        // R12: write collision and read during write
        cyc(1, 0, 9'h014, 32'h1111_1111, 1, 0, 9'h014, 32'h2222_2222);
        rread(9'h014, v); chk("R12 host wins collision", v, 32'h1111_1111);
        cyc(1, 0, 9'h01C, 32'hCAFE_F00D, 0, 1, 9'h01C, '0);
        chk("R12 read old during write", rem_rdata, ~pat(7));
        hread(9'h01C, v); chk("R12 new data after write", v, 32'hCAFE_F00D);

        // R10: every unmapped word offset
        for (int w = 65; w < 128; w++) begin
            if (w == 67) continue;
            cyc(1, 0, 9'(w*4), 32'hFFFF_FFFF, 1, 0, 9'(w*4), 32'hFFFF_FFFF);
            hread(9'(w*4), v); chk("R10 unmapped host read", v, 32'd0);
            rread(9'(w*4), v); chk("R10 unmapped remote read", v, 32'd0);
        end
        hread(TX, v); chk("R10 tx untouched", v, exp_tx);
        hread(RX, v); chk("R10 rx untouched", v, exp_rx);
        hread(9'h000, v); chk("R10 buffer untouched", v, ~pat(0));

        // R11: reset in mid-run with both registers pending
        hwrite(TX, 32'hA5A5_0001); rwrite(RX, 32'h0000_0F00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq cleared", {31'd0, host_irq}, 32'd0);
        hread(TX, v); chk("R11 tx cleared", v, 32'd0);
        rread(RX, v); chk("R11 rx cleared", v, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule